// File: doc/BRIEF.md
# Kick-Committed Fractional Clock Divider

This block turns a free-running input clock into a stream of clock-enable pulses whose average rate is a programmable fraction of that clock. A 5-bit reduction code `code` selects a multiplier of (32 − code). A phase accumulator emits (32 − code) evenly spaced pulses in every frame of 32 input cycles. A fixed divide-by-two stage then passes every second of those pulses. So the final enable rate is input × (32 − code) / 64. All outputs are enables in the input clock domain.

Software reaches the block over a simple register bus with address, write data, write strobe, read strobe and registered read data. A new code is written into a staging register and does nothing at first. To apply it, software writes 1 to a commit bit in a separate register. The hardware copies the staged code into the running ratio at the next frame boundary and then clears the commit bit by itself. Software polls that bit to learn that the change is complete. The delay is bounded by one frame, whatever ratio is programmed.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, the control register (byte offset 0xE0) and the commit register (byte offset 0x04) both read 0. The active multiplier is 32, so `fracEn` pulses every cycle and `clkEn` pulses every other cycle.
- R2: While the active code c is constant, every 32 consecutive cycles contain exactly 32 − c pulses on `fracEn`. Code 0 gives 32 pulses and code 31 gives 1 pulse.
- R3: `clkEn` pulses only together with a `fracEn` pulse, on every second one. Over 64 cycles of constant code c, `clkEn` therefore pulses exactly 32 − c times.
- R4: Writing the control register updates the staged code at bits 12:8, which reads back at once. The active ratio and the `fracEn` rate stay unchanged until a commit.
- R5: All 32 bits of the control register are read/write storage. Bits outside 12:8 keep whatever value was written last.
- R6: Writing a word with bit 31 set to offset 0x04 sets the commit bit. That bit reads back in bit 31 while the change is pending, and all other bits of offset 0x04 read 0.
- R7: The staged code becomes active at the clock edge that ends a 32-cycle frame, counted from reset. The commit bit reads 0 from the edge after that one, so a change completes within 34 cycles of the commit write.
- R8: Writing 0 to the commit register never clears a pending commit. Writing 1 again while a commit is pending has no extra effect.
- R9: Read data is registered. It is valid in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Write data |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regRdata | output | 32 | Registered read data |
| fracEn | output | 1 | Enable pulses from the fractional stage |
| clkEn | output | 1 | Enable pulses after the fixed divide-by-two |

## Verification
The bench builds the block with its default parameters: a 5-bit code, a 32-cycle frame, the control register at 0xE0 and the commit register at 0x04. The frame is short enough that every commit settles within a few dozen cycles. The bench therefore counts the frame phase from reset and predicts the exact read at which the commit bit drops. It also measures pulse counts for both extreme codes (0 and 31) and for an odd multiplier, all within 64-cycle windows.

// File: rtl/frac_clk_div_pkg.sv
package frac_clk_div_pkg;
  // Width of the ratio code; the frame holds 2**ZCODE_W cycles.
  localparam int unsigned ZCODE_W = 5;

  // Strobes from the control side into the datapath.
  typedef struct packed {
    logic               load;
    logic [ZCODE_W-1:0] code;
  } zdivCmd_t;
endpackage

// File: rtl/frac_clk_div_ctrl.sv
module frac_clk_div_ctrl
  import frac_clk_div_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTRL_OFS  = 'hE0,
  parameter int unsigned KICK_OFS  = 'h04,
  parameter int unsigned FIELD_LSB = 8,
  parameter int unsigned KICK_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              frameEnd,
  output logic [DATA_W-1:0] regRdata,
  output zdivCmd_t          cmd
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] KICK_A = ADDR_W'(KICK_OFS);

  logic [DATA_W-1:0] ctrlReg;
  logic              kickPending;
  logic              loadDone;
  logic              wrCtrl;
  logic              wrKick;
  logic [DATA_W-1:0] kickWord;

  assign wrCtrl = regWr && (regAddr == CTRL_A);
  assign wrKick = regWr && (regAddr == KICK_A);

  // Staging register: the whole word is storage; only the field is used.
  always_ff @(posedge clk) begin
    if (!rst_n)      ctrlReg <= '0;
    else if (wrCtrl) ctrlReg <= regWdata;
  end

  // Commit request: set by software, cleared one cycle after the copy.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kickPending <= 1'b0;
      loadDone    <= 1'b0;
    end else begin
      loadDone <= cmd.load;
      if (loadDone)                          kickPending <= 1'b0;
      else if (wrKick && regWdata[KICK_BIT]) kickPending <= 1'b1;
    end
  end

  always_comb begin
    cmd.load = kickPending && frameEnd && !loadDone;
    cmd.code = ctrlReg[FIELD_LSB +: ZCODE_W];
  end

  always_comb begin
    kickWord           = '0;
    kickWord[KICK_BIT] = kickPending;
  end

  // Registered read port; data holds between reads.
  always_ff @(posedge clk) begin
    if (!rst_n) regRdata <= '0;
    else if (regRd) begin
      case (regAddr)
        CTRL_A:  regRdata <= ctrlReg;
        KICK_A:  regRdata <= kickWord;
        default: regRdata <= '0;
      endcase
    end
  end

  // R6
  kick_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kickPending) |-> $past(wrKick && regWdata[KICK_BIT]));

  // R8
  kick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kickPending && !loadDone) |=> kickPending);

  // R7
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.load |=> (kickPending ##1 !kickPending));
endmodule

// File: rtl/frac_clk_div_dp.sv
module frac_clk_div_dp
  import frac_clk_div_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  zdivCmd_t cmd,
  output logic     frameEnd,
  output logic     fracEn,
  output logic     clkEn
);
  localparam int unsigned FRAME  = 1 << ZCODE_W;
  localparam int unsigned MULT_W = ZCODE_W + 1;
  localparam logic [MULT_W-1:0] FRAME_V = MULT_W'(FRAME);

  logic [ZCODE_W-1:0] activeCode;
  logic [ZCODE_W-1:0] acc;
  logic [ZCODE_W-1:0] frameCnt;
  logic [MULT_W-1:0]  mult;
  logic [MULT_W-1:0]  sum;
  logic               carry;
  logic               divPhase;

  assign mult     = FRAME_V - {1'b0, activeCode};
  assign sum      = {1'b0, acc} + mult;
  assign carry    = sum[ZCODE_W];
  assign frameEnd = &frameCnt;

  // Frame counter and active ratio: the ratio changes only at frame end.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frameCnt   <= '0;
      activeCode <= '0;
    end else begin
      frameCnt <= frameCnt + 1'b1;
      if (cmd.load) activeCode <= cmd.code;
    end
  end

  // Phase accumulator; restarts each frame so spacing is frame-aligned.
  always_ff @(posedge clk) begin
    if (!rst_n)        acc <= '0;
    else if (frameEnd) acc <= '0;
    else               acc <= sum[ZCODE_W-1:0];
  end

  // Fractional pulse and fixed halving stage.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fracEn   <= 1'b0;
      clkEn    <= 1'b0;
      divPhase <= 1'b0;
    end else begin
      fracEn   <= carry;
      clkEn    <= carry && divPhase;
      divPhase <= divPhase ^ carry;
    end
  end

  // Checker counter: carries seen so far in the current frame.
  logic [MULT_W-1:0] pulseCnt;
  always_ff @(posedge clk) begin
    if (!rst_n)        pulseCnt <= '0;
    else if (frameEnd) pulseCnt <= '0;
    else               pulseCnt <= pulseCnt + MULT_W'(carry);
  end

  // R2
  frame_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameEnd |-> ((pulseCnt + MULT_W'(carry)) == mult));

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.load |=> $stable(activeCode));

  // R3
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkEn |-> fracEn);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_clk_div_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTRL_OFS  = 'hE0,
  parameter int unsigned KICK_OFS  = 'h04,
  parameter int unsigned FIELD_LSB = 8,
  parameter int unsigned KICK_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWr,
  input  logic              regRd,
  output logic [DATA_W-1:0] regRdata,
  output logic              fracEn,
  output logic              clkEn
);
  zdivCmd_t cmd;
  logic     frameEnd;

  frac_clk_div_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS),
    .KICK_OFS(KICK_OFS), .FIELD_LSB(FIELD_LSB), .KICK_BIT(KICK_BIT)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWdata(regWdata),
    .regWr(regWr), .regRd(regRd), .frameEnd(frameEnd),
    .regRdata(regRdata), .cmd(cmd)
  );

  frac_clk_div_dp i_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .frameEnd(frameEnd), .fracEn(fracEn), .clkEn(clkEn)
  );
endmodule

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regRdata;
  logic        fracEn;
  logic        clkEn;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  localparam logic [7:0] A_CTRL = 8'hE0;
  localparam logic [7:0] A_KICK = 8'h04;

  frac_clk_div i_frac_clk_div (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWdata(regWdata),
    .regWr(regWr), .regRd(regRd), .regRdata(regRdata),
    .fracEn(fracEn), .clkEn(clkEn)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic countWindow(input int n, output int f, output int o);
    f = 0; o = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      f += int'(fracEn);
      o += int'(clkEn);
    end
  endtask

  // Commits the staged code and polls until done; returns reads taken.
  task automatic commitAndWait(input logic [31:0] kickVal, output int polls);
    logic [31:0] d;
    busWrite(A_KICK, kickVal);
    busRead(A_KICK, d);
    check(d == 32'h8000_0000, "R6", d, 32'h8000_0000);
    polls = 1;
    while (d != 0 && polls < 60) begin
      busRead(A_KICK, d);
      polls++;
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    int f, o;
    busRead(A_CTRL, d);
    check(d == 0, "R1", d, 0);
    busRead(A_KICK, d);
    check(d == 0, "R1", d, 0);
    countWindow(64, f, o);
    check(f == 64, "R1", f, 64);
    check(o == 32, "R1", o, 32);
  endtask

  task automatic testStaging();
    logic [31:0] d;
    int f, o;
    busWrite(A_CTRL, 32'h0000_1800);
    busRead(A_CTRL, d);
    check(d == 32'h0000_1800, "R4", d, 32'h1800);
    // R9: data holds with no read strobe
    @(negedge clk);
    check(regRdata == 32'h0000_1800, "R9", regRdata, 32'h1800);
    countWindow(64, f, o);
    check(f == 64, "R4", f, 64);
  endtask

  task automatic testRatio(input int code);
    int polls, f, o, m;
    m = 32 - code;
    busWrite(A_CTRL, 32'(code) << 8);
    commitAndWait(32'h8000_0000, polls);
    check(polls <= 34, "R7", polls, 34);
    countWindow(64, f, o);
    check(f == 2 * m, "R2", f, 2 * m);
    check(o == m, "R3", o, m);
  endtask

  task automatic testOtherBits();
    logic [31:0] d;
    int polls, f, o;
    busWrite(A_CTRL, 32'hA5A5_F05A);
    busRead(A_CTRL, d);
    check(d == 32'hA5A5_F05A, "R5", d, 32'hA5A5_F05A);
    commitAndWait(32'hFFFF_FFFF, polls);
    countWindow(64, f, o);
    check(f == 32, "R5", f, 32);
    busRead(A_CTRL, d);
    check(d == 32'hA5A5_F05A, "R5", d, 32'hA5A5_F05A);
  endtask

  task automatic testHoldAndTiming();
    logic [31:0] d;
    logic [31:0] exp;
    int f, o;
    busWrite(A_CTRL, 32'h0000_1000);
    while ((cyc % 32) != 4) @(negedge clk);
    busWrite(A_KICK, 32'h8000_0000);
    busWrite(A_KICK, 32'h0000_0000);
    busWrite(A_KICK, 32'h8000_0000);
    busRead(A_KICK, d);
    check(d == 32'h8000_0000, "R8", d, 32'h8000_0000);
    regAddr = A_KICK; regRd = 1'b1;
    do begin
      @(negedge clk);
      exp = ((cyc % 32) == 2) ? 32'h0 : 32'h8000_0000;
      check(regRdata == exp, "R7", regRdata, exp);
    end while ((cyc % 32) != 2);
    regRd = 1'b0;
    countWindow(64, f, o);
    check(f == 32, "R8", f, 32);
    check(o == 16, "R3", o, 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testStaging();
    testRatio(24);
    testRatio(31);
    testRatio(0);
    testRatio(13);
    testOtherBits();
    testHoldAndTiming();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule